// File: doc/BRIEF.md
# Byte-Wide Sampling-Converter Read Controller

This block is the host-side master for a 16-bit sampling converter whose result is read over an 8-bit data path. A conversion starts on a one-cycle start request or on a periodic trigger. The controller first lowers chip-select. It then pulses convert-start low and high, and waits for the converter's busy line to fall. Next it fetches the result in two byte reads. In the first read byte-select is low and the upper eight result bits come in. In the second read byte-select is high and the lower eight result bits come in on the same eight pins.

The two bytes are joined into one 16-bit word. That word is presented with a one-cycle valid pulse. Every pin-timing window is a parameter counted in clock cycles, with defaults sized for a 100 MHz clock. Bus activity is kept out of a quiet window around each convert-start falling edge.

After reset, the first three completed conversions are discarded so that the converter's internal state can settle. If busy does not fall within a bounded number of cycles, an error flag is set and the controller returns to idle without reporting a sample.

Top module: `adcrd_ctrl`

## Requirements
- R1: After reset, chip-select, convert-start and read strobe are high (inactive), byte-select is 0, the valid strobe is 0 and the error flag is 0.
- R2: Convert-start falls only while chip-select is already low, and it stays low for exactly T_CNV_LO cycles (default 2).
- R3: The first read strobe falls no earlier than T_QUIET_POST cycles (default 4) after convert-start falls, and only once busy has been sampled low.
- R4: The first read keeps byte-select at 0 and holds the read strobe low for max(T_RD_LO, T_EN) cycles (default 5). The bus byte captured at the end of that read becomes result bits 15..8.
- R5: Byte-select rises together with the first read strobe's rising edge. It is high for max(T_BYTE_DLY, T_RD_HI, T_BYTE_GAP - read width) cycles (default 23) before the second read strobe falls. The bus byte captured in the second read becomes result bits 7..0.
- R6: Byte-select never changes while the read strobe is low. Two byte-select changes are at least T_BYTE_GAP cycles (default 5) apart. The read strobe is high for at least T_RD_HI cycles (default 2) between the two reads.
- R7: The next convert-start falling edge comes at least max(T_QUIET_PRE, T_RD2CNV) cycles (default 5) after the last read strobe rises and byte-select falls.
- R8: The first DUMMY_CNT (default 3) completed conversions after reset produce no valid pulse. Every later completed conversion gives a valid pulse exactly one cycle wide, carrying the assembled sample.
- R9: If busy is still high after BUSY_TMO cycles (default 100) of waiting, the error flag is set, chip-select is raised, no valid pulse is produced and the controller goes idle. The flag clears when the next conversion is requested.
- R10: A start request or periodic trigger that arrives while a conversion is in progress is ignored: it causes no additional convert-start pulse.
- R11: While the trigger enable is high, a conversion is requested every PERIOD cycles (default 400). Consecutive convert-start falling edges are therefore exactly PERIOD cycles apart.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_req | input | 1 | One-cycle request for a single conversion |
| trig_en | input | 1 | Enables the periodic conversion trigger |
| adc_busy | input | 1 | Converter busy, high during conversion |
| adc_db | input | BYTE_W | Upper byte lane of the converter's data bus |
| adc_cs_n | output | 1 | Chip-select, active low |
| adc_convst_n | output | 1 | Convert-start, active low |
| adc_rd_n | output | 1 | Read strobe, active low |
| adc_byte_sel | output | 1 | Byte-select: 0 gives high byte, 1 gives low byte |
| sample_o | output | 2*BYTE_W | Assembled result |
| sample_vld | output | 1 | One-cycle strobe qualifying sample_o |
| busy_tmo_err | output | 1 | Set when busy failed to fall in time |

## Verification
The bench targets the byte ordering, the discarded warm-up conversions, busy that never falls, and requests made while a conversion is already running. A design that swapped the bytes or sampled before byte-select settled would return wrong words for asymmetric patterns such as 0x1234 and 0x7FFF. One that miscounted the warm-up would report a sample too early or too late after reset. A controller that ignored the timeout would hang, or would emit a spurious sample with the error flag still clear. One that accepted a second request mid-conversion would pulse convert-start inside the read sequence. Pin timing is measured edge by edge against the cycle windows: convert-start width, the quiet time before the first read, byte-select hold before the second read, and recovery before the next convert-start.

// File: rtl/adcrd_pkg.sv
`timescale 1ns/1ps
package adcrd_pkg;

  typedef enum logic [3:0] {
    S_IDLE,
    S_CSLO,
    S_CNVLO,
    S_CNVHI,
    S_WBUSY,
    S_RD1,
    S_BYTE,
    S_RD2,
    S_REC
  } seq_st_e;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/adcrd_timer.sv
`timescale 1ns/1ps
module adcrd_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)              cnt_q <= '0;
    else if (load)        cnt_q <= load_val;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/adcrd_trigger.sv
`timescale 1ns/1ps
module adcrd_trigger #(
  parameter int PERIOD = 400,
  parameter int CNT_W  = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic tick
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt_q <= '0;
      tick  <= 1'b0;
    end else if (cnt_q == CNT_W'(PERIOD - 1)) begin
      cnt_q <= '0;
      tick  <= 1'b1;
    end else begin
      cnt_q <= cnt_q + 1'b1;
      tick  <= 1'b0;
    end
  end

endmodule

// File: rtl/adcrd_seq.sv
`timescale 1ns/1ps
module adcrd_seq
  import adcrd_pkg::*;
#(
  parameter int BYTE_W       = 8,
  parameter int CNT_W        = 16,
  parameter int T_CNV_LO     = 2,
  parameter int T_CNV_HI     = 2,
  parameter int T_QUIET_POST = 4,
  parameter int T_QUIET_PRE  = 5,
  parameter int T_RD_LO      = 5,
  parameter int T_RD_HI      = 2,
  parameter int T_EN         = 3,
  parameter int T_BYTE_DLY   = 23,
  parameter int T_BYTE_GAP   = 5,
  parameter int T_RD2CNV     = 5,
  parameter int BUSY_TMO     = 100,
  parameter int DUMMY_CNT    = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                go,
  input  logic                busy_i,
  input  logic [BYTE_W-1:0]   data_i,
  output logic                cs_n_o,
  output logic                convst_n_o,
  output logic                rd_n_o,
  output logic                byte_sel_o,
  output logic [2*BYTE_W-1:0] sample_o,
  output logic                sample_vld_o,
  output logic                err_o
);

  localparam int L_CNVLO = max2(T_CNV_LO, 1);
  localparam int L_HOLD  = max2(max2(T_CNV_HI, T_QUIET_POST - L_CNVLO), 1);
  localparam int L_RDLO  = max2(max2(T_RD_LO, T_EN), 1);
  localparam int L_BYTE  = max2(max2(T_BYTE_DLY, T_RD_HI), max2(T_BYTE_GAP - L_RDLO, 1));
  localparam int L_REC   = max2(max2(T_QUIET_PRE, T_RD2CNV), 1);
  localparam int L_TMO   = max2(BUSY_TMO, 1);
  localparam int DW      = $clog2(DUMMY_CNT + 2);

  seq_st_e          st_q, nxt;
  logic             t_load, t_exp;
  logic [CNT_W-1:0] t_val;
  logic             cap_hi, cap_lo, tmo;
  logic [BYTE_W-1:0] hi_q;
  logic [DW-1:0]    done_q;

  adcrd_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (t_load),
    .load_val (t_val),
    .expired  (t_exp)
  );

  always_comb begin
    nxt    = st_q;
    t_load = 1'b0;
    t_val  = '0;
    cap_hi = 1'b0;
    cap_lo = 1'b0;
    tmo    = 1'b0;
    case (st_q)
      S_IDLE:  if (go) nxt = S_CSLO;
      S_CSLO: begin
        nxt = S_CNVLO; t_load = 1'b1; t_val = CNT_W'(L_CNVLO - 1);
      end
      S_CNVLO: if (t_exp) begin
        nxt = S_CNVHI; t_load = 1'b1; t_val = CNT_W'(L_HOLD - 1);
      end
      S_CNVHI: if (t_exp) begin
        nxt = S_WBUSY; t_load = 1'b1; t_val = CNT_W'(L_TMO - 1);
      end
      S_WBUSY: begin
        if (!busy_i) begin
          nxt = S_RD1; t_load = 1'b1; t_val = CNT_W'(L_RDLO - 1);
        end else if (t_exp) begin
          nxt = S_IDLE; tmo = 1'b1;
        end
      end
      S_RD1: if (t_exp) begin
        cap_hi = 1'b1; nxt = S_BYTE; t_load = 1'b1; t_val = CNT_W'(L_BYTE - 1);
      end
      S_BYTE: if (t_exp) begin
        nxt = S_RD2; t_load = 1'b1; t_val = CNT_W'(L_RDLO - 1);
      end
      S_RD2: if (t_exp) begin
        cap_lo = 1'b1; nxt = S_REC; t_load = 1'b1; t_val = CNT_W'(L_REC - 1);
      end
      S_REC:   if (t_exp) nxt = S_IDLE;
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q         <= S_IDLE;
      cs_n_o       <= 1'b1;
      convst_n_o   <= 1'b1;
      rd_n_o       <= 1'b1;
      byte_sel_o   <= 1'b0;
      hi_q         <= '0;
      sample_o     <= '0;
      sample_vld_o <= 1'b0;
      err_o        <= 1'b0;
      done_q       <= '0;
    end else begin
      st_q       <= nxt;
      cs_n_o     <= (nxt == S_IDLE);
      convst_n_o <= (nxt != S_CNVLO);
      rd_n_o     <= !((nxt == S_RD1) || (nxt == S_RD2));
      byte_sel_o <= (nxt == S_BYTE) || (nxt == S_RD2);
      if (cap_hi) hi_q <= data_i;
      sample_vld_o <= 1'b0;
      if (cap_lo) begin
        sample_o     <= {hi_q, data_i};
        sample_vld_o <= (done_q == DW'(DUMMY_CNT));
        if (done_q != DW'(DUMMY_CNT)) done_q <= done_q + 1'b1;
      end
      if (tmo)                        err_o <= 1'b1;
      else if (st_q == S_IDLE && go)  err_o <= 1'b0;
    end
  end

  logic [CNT_W-1:0] cnv_lo_cnt;
  always_ff @(posedge clk) begin
    if (rst)              cnv_lo_cnt <= '0;
    else if (!convst_n_o) cnv_lo_cnt <= cnv_lo_cnt + 1'b1;
    else                  cnv_lo_cnt <= '0;
  end

  // R2
  cnv_cs_low_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(convst_n_o) |-> !cs_n_o);

  // R2
  cnv_width_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(convst_n_o) |-> (cnv_lo_cnt == CNT_W'(L_CNVLO)));

  // R3
  rd_after_busy_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(rd_n_o) && !byte_sel_o) |-> !$past(busy_i));

  // R6
  byte_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (!rd_n_o && $past(!rd_n_o)) |-> $stable(byte_sel_o));

  // R8
  vld_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    sample_vld_o |=> !sample_vld_o);

  // R9
  tmo_idle_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(err_o) |-> (cs_n_o && !sample_vld_o));

endmodule

// File: rtl/adcrd_ctrl.sv
`timescale 1ns/1ps
module adcrd_ctrl #(
  parameter int BYTE_W       = 8,
  parameter int CNT_W        = 16,
  parameter int T_CNV_LO     = 2,
  parameter int T_CNV_HI     = 2,
  parameter int T_QUIET_POST = 4,
  parameter int T_QUIET_PRE  = 5,
  parameter int T_RD_LO      = 5,
  parameter int T_RD_HI      = 2,
  parameter int T_EN         = 3,
  parameter int T_BYTE_DLY   = 23,
  parameter int T_BYTE_GAP   = 5,
  parameter int T_RD2CNV     = 5,
  parameter int BUSY_TMO     = 100,
  parameter int DUMMY_CNT    = 3,
  parameter int PERIOD       = 400
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start_req,
  input  logic                trig_en,
  input  logic                adc_busy,
  input  logic [BYTE_W-1:0]   adc_db,
  output logic                adc_cs_n,
  output logic                adc_convst_n,
  output logic                adc_rd_n,
  output logic                adc_byte_sel,
  output logic [2*BYTE_W-1:0] sample_o,
  output logic                sample_vld,
  output logic                busy_tmo_err
);

  logic tick;

  adcrd_trigger #(.PERIOD(PERIOD), .CNT_W(CNT_W)) u_trig (
    .clk  (clk),
    .rst  (rst),
    .en   (trig_en),
    .tick (tick)
  );

  adcrd_seq #(
    .BYTE_W(BYTE_W), .CNT_W(CNT_W),
    .T_CNV_LO(T_CNV_LO), .T_CNV_HI(T_CNV_HI),
    .T_QUIET_POST(T_QUIET_POST), .T_QUIET_PRE(T_QUIET_PRE),
    .T_RD_LO(T_RD_LO), .T_RD_HI(T_RD_HI), .T_EN(T_EN),
    .T_BYTE_DLY(T_BYTE_DLY), .T_BYTE_GAP(T_BYTE_GAP),
    .T_RD2CNV(T_RD2CNV), .BUSY_TMO(BUSY_TMO), .DUMMY_CNT(DUMMY_CNT)
  ) u_seq (
    .clk          (clk),
    .rst          (rst),
    .go           (start_req | tick),
    .busy_i       (adc_busy),
    .data_i       (adc_db),
    .cs_n_o       (adc_cs_n),
    .convst_n_o   (adc_convst_n),
    .rd_n_o       (adc_rd_n),
    .byte_sel_o   (adc_byte_sel),
    .sample_o     (sample_o),
    .sample_vld_o (sample_vld),
    .err_o        (busy_tmo_err)
  );

endmodule

// File: tb/adcrd_ctrl_tb.sv
`timescale 1ns/1ps
module adcrd_ctrl_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_req = 1'b0;
  logic        trig_en = 1'b0;
  logic        busy = 1'b0;
  logic [7:0]  db;
  logic        cs_n, convst_n, rd_n, byte_sel, vld, err;
  logic [15:0] sample;

  always #10 clk = ~clk;

  adcrd_ctrl u_dut (
    .clk(clk), .rst(rst), .start_req(start_req), .trig_en(trig_en),
    .adc_busy(busy), .adc_db(db), .adc_cs_n(cs_n), .adc_convst_n(convst_n),
    .adc_rd_n(rd_n), .adc_byte_sel(byte_sel), .sample_o(sample),
    .sample_vld(vld), .busy_tmo_err(err)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // converter model
  logic [15:0] cur_val = 16'h0;
  bit          hang = 0;
  int          conv_left = 0;
  logic        prev_cnv = 1'b1;

  always @(posedge clk) begin
    prev_cnv <= convst_n;
    if (rst) begin
      busy <= 1'b0;
    end else if (prev_cnv && !convst_n) begin
      busy      <= 1'b1;
      conv_left <= 20;
    end else if (busy) begin
      if (conv_left != 0) conv_left <= conv_left - 1;
      else if (!hang)     busy <= 1'b0;
    end
  end

  assign db = (!cs_n && !rd_n) ? (byte_sel ? cur_val[7:0] : cur_val[15:8]) : 8'hA5;

  // pin-timing monitor
  int cyc = 0;
  int t_cf = 0, t_rf = 0, t_rr = 0, t_br = 0, t_bf = 0;
  bit have_rr = 0, have_cf = 0;
  int n_cnv = 0, last_gap = 0, n_vld = 0;
  logic [15:0] last_sample = 16'h0;
  logic p_cnv = 1'b1, p_rd = 1'b1, p_byte = 1'b0;

  always @(negedge clk) begin
    cyc++;
    if (rst) begin
      p_cnv = 1'b1; p_rd = 1'b1; p_byte = 1'b0;
      have_rr = 0; have_cf = 0;
    end else begin
      if (p_cnv && !convst_n) begin
        chk(!cs_n, "R2 cs low at convst fall", cs_n, 0);
        if (have_rr) chk(cyc - t_rr >= 5, "R7 read-to-convst gap", cyc - t_rr, 5);
        if (have_cf) last_gap = cyc - t_cf;
        t_cf = cyc; have_cf = 1; n_cnv++;
      end
      if (!p_cnv && convst_n) chk(cyc - t_cf == 2, "R2 convst low width", cyc - t_cf, 2);
      if (p_rd && !rd_n) begin
        t_rf = cyc;
        if (!byte_sel) begin
          chk(cyc - t_cf >= 4, "R3 quiet after convst", cyc - t_cf, 4);
          chk(!busy, "R3 busy low at read", busy, 0);
        end else begin
          chk(cyc - t_br == 23, "R5 byte-select setup", cyc - t_br, 23);
          chk(cyc - t_rr >= 2, "R6 read high time", cyc - t_rr, 2);
        end
      end
      if (!p_rd && rd_n) begin
        chk(cyc - t_rf == 5, "R4 read low width", cyc - t_rf, 5);
        t_rr = cyc; have_rr = 1;
      end
      if (p_byte != byte_sel) begin
        chk(rd_n, "R6 byte change with read low", rd_n, 1);
        if (byte_sel) begin
          chk(cyc - t_bf >= 5, "R6 byte gap", cyc - t_bf, 5);
          t_br = cyc;
        end else begin
          chk(cyc - t_br >= 5, "R6 byte gap", cyc - t_br, 5);
          t_bf = cyc;
        end
      end
      if (vld) begin
        n_vld++;
        last_sample = sample;
      end
      p_cnv = convst_n; p_rd = rd_n; p_byte = byte_sel;
    end
  end

  task automatic pulse_start();
    @(negedge clk) start_req = 1'b1;
    @(negedge clk) start_req = 1'b0;
  endtask

  task automatic run_conv(input logic [15:0] val, input int exp_v, input string req);
    int nv;
    nv = n_vld;
    cur_val = val;
    pulse_start();
    repeat (150) @(negedge clk);
    chk(n_vld - nv == exp_v, req, n_vld - nv, exp_v);
    if (exp_v == 1) chk(last_sample == val, req, last_sample, val);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(cs_n && convst_n && rd_n, "R1 strobes idle", {cs_n, convst_n, rd_n}, 7);
    chk(!byte_sel, "R1 byte-select", byte_sel, 0);
    chk(!vld && !err, "R1 valid/error", {vld, err}, 0);
  endtask

  task automatic t_warmup();
    int c0;
    c0 = n_cnv;
    for (int i = 0; i < 3; i++) run_conv(16'h4321 + 16'(i), 0, "R8 dummy conversion no valid");
    chk(n_cnv - c0 == 3, "R8 dummy conversions issued", n_cnv - c0, 3);
    run_conv(16'hBEEF, 1, "R8 first reported sample");
  endtask

  task automatic t_patterns();
    logic [15:0] pats [5] = '{16'h0000, 16'hFFFF, 16'h8000, 16'h7FFF, 16'h1234};
    foreach (pats[i]) run_conv(pats[i], 1, "R4 R5 byte assembly");
  endtask

  task automatic t_ignore();
    int c0, nv;
    c0 = n_cnv; nv = n_vld;
    cur_val = 16'hC3A1;
    pulse_start();
    repeat (8) @(negedge clk);
    pulse_start();
    repeat (30) @(negedge clk);
    pulse_start();
    repeat (150) @(negedge clk);
    chk(n_cnv - c0 == 1, "R10 start while active ignored", n_cnv - c0, 1);
    chk(n_vld - nv == 1, "R10 single sample", n_vld - nv, 1);
    chk(last_sample == 16'hC3A1, "R10 sample value", last_sample, 16'hC3A1);
  endtask

  task automatic t_timeout();
    int nv;
    nv = n_vld;
    hang = 1;
    pulse_start();
    repeat (150) @(negedge clk);
    chk(err, "R9 error flag set", err, 1);
    chk(cs_n, "R9 chip-select released", cs_n, 1);
    chk(n_vld == nv, "R9 no sample on timeout", n_vld - nv, 0);
    hang = 0;
    repeat (5) @(negedge clk);
    run_conv(16'h5AA5, 1, "R9 recovery after timeout");
    chk(!err, "R9 error cleared by new request", err, 0);
  endtask

  task automatic t_periodic();
    int c0;
    c0 = n_cnv;
    trig_en = 1'b1;
    repeat (1000) @(negedge clk);
    trig_en = 1'b0;
    repeat (150) @(negedge clk);
    chk(n_cnv - c0 == 2, "R11 periodic conversions", n_cnv - c0, 2);
    chk(last_gap == 400, "R11 trigger period", last_gap, 400);
  endtask

  initial begin
    t_reset();
    t_warmup();
    t_patterns();
    t_ignore();
    t_timeout();
    t_periodic();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      chk(0, "watchdog", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

endmodule